// File: doc/BRIEF.md
# Rank Sparing Failover Controller

This controller decides when a memory rank that has built up too many correctable errors should be copied onto a spare rank. It then tracks that copy until the spare takes over. Each rank has an at-limit flag from an error-counting stage. While sparing is enabled and exactly one of those flags is high, the controller records which rank failed, marks a copy as in progress and pulses a start strobe to an external data mover. When the mover reports that the copy is done, the controller reports that the spare has taken over. It holds that status until software removes the sparing enable.

The data mover and the address remapping sit outside this block. Their only links to it are the copy-start strobe and the copy-done input. All pins are plain control and status levels or single-cycle strobes. No data flows through the block, so no port carries a valid/ready handshake. Every state element is reset by an active-low reset.

Top module: `rank_spare_ctrl`

## Requirements
- R1: In the idle condition (copy_busy and spare_active both low), if spare_en is high and exactly one bit of rank_at_limit is high at a rising edge, copy_busy is high after that edge.
- R2: In the idle condition, if no bit or two or more bits of rank_at_limit are high, copy_busy stays low after the edge.
- R3: copy_busy stays high until copy_done is sampled high. After that edge spare_active is high and copy_busy is low, whatever spare_en and rank_at_limit do.
- R4: copy_start and evt_copy_began are both high for exactly one cycle, and that cycle is the first cycle in which copy_busy is high.
- R5: evt_failover is high for exactly one cycle, and that cycle is the first cycle in which spare_active is high.
- R6: spare_active stays high while spare_en is sampled high. After the first edge at which spare_en is sampled low, spare_active is low.
- R7: When a copy starts, failed_rank holds the binary index i of the single high bit rank_at_limit[i] (bit 0 gives 0, bit 11 gives 11). It keeps that value until the next copy starts.
- R8: While spare_active is high, no copy starts for any rank. A new copy needs spare_en to go low and then high again.
- R9: copy_done has no effect while copy_busy is low. copy_busy and spare_active are never high together.
- R10: During and right after reset, copy_busy, spare_active, copy_start, evt_copy_began and evt_failover are 0, and failed_rank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spare_en | input | 1 | Sparing enable |
| rank_at_limit | input | 12 | Per-rank error-limit reached flags |
| copy_done | input | 1 | Copy finished strobe from data mover |
| copy_busy | output | 1 | Copy in progress |
| spare_active | output | 1 | Spare has replaced failed rank |
| failed_rank | output | 4 | Index of the rank being spared |
| copy_start | output | 1 | One-cycle request to begin copying |
| evt_copy_began | output | 1 | Error event: copy started |
| evt_failover | output | 1 | Error event: failover reached |

## Verification
Two things can fall in the same cycle: the copy-done strobe, and a drop of the sparing enable or a fresh single at-limit flag. The copy must still end in failover, and failover must then release one cycle later if the enable is low. The bench forces this case directly and also hits it through random enable toggling and random at-limit patterns. A bench model steps the three-state behaviour once per cycle, and every output is compared against it after each edge. This includes checking that the failover event fires even when failover lasts only one cycle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COPY   = 2'd1,
    ST_FAILED = 2'd2
  } rsc_state_e;
endpackage

// File: rtl/rsc_rank_select.sv
module rsc_rank_select #(
  parameter int NUM_RANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_RANKS-1:0] lim,
  output logic                 single,
  output logic [IDX_W-1:0]     idx
);
  logic [NUM_RANKS-1:0] lim_minus;
  logic [IDX_W-1:0]     part [NUM_RANKS];

  assign lim_minus = lim - NUM_RANKS'(1);
  assign single    = (lim != '0) && ((lim & lim_minus) == '0);

  // each position contributes its own index when its flag is set
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_part
    assign part[g] = lim[g] ? IDX_W'(g) : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_RANKS; i++) idx = idx | part[i];
  end
endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm #(
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spare_en,
  input  logic                  single,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  copy_done,
  output rsc_pkg::rsc_state_e   state,
  output logic [IDX_W-1:0]      rank_q,
  output logic                  start_q
);
  import rsc_pkg::*;
  rsc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (spare_en && single) nxt = ST_COPY;
      ST_COPY:   if (copy_done)          nxt = ST_FAILED;
      ST_FAILED: if (!spare_en)          nxt = ST_IDLE;
      default:                           nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rank_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= (state == ST_IDLE) && (nxt == ST_COPY);
      if ((state == ST_IDLE) && (nxt == ST_COPY)) rank_q <= idx;
    end
  end
endmodule

// File: rtl/rsc_events.sv
module rsc_events (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic active,
  output logic evt_busy_rise,
  output logic evt_active_rise
);
  logic busy_d, active_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d   <= 1'b0;
      active_d <= 1'b0;
    end else begin
      busy_d   <= busy;
      active_d <= active;
    end
  end

  assign evt_busy_rise   = busy & ~busy_d;
  assign evt_active_rise = active & ~active_d;
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl #(
  parameter int NUM_RANKS = 12,
  localparam int IDX_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spare_en,
  input  logic [NUM_RANKS-1:0] rank_at_limit,
  input  logic                 copy_done,
  output logic                 copy_busy,
  output logic                 spare_active,
  output logic [IDX_W-1:0]     failed_rank,
  output logic                 copy_start,
  output logic                 evt_copy_began,
  output logic                 evt_failover
);
  import rsc_pkg::*;

  logic             single;
  logic [IDX_W-1:0] idx;
  rsc_state_e       state;

  rsc_rank_select #(.NUM_RANKS(NUM_RANKS), .IDX_W(IDX_W)) u_sel (
    .lim(rank_at_limit), .single(single), .idx(idx)
  );

  rsc_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .spare_en(spare_en), .single(single),
    .idx(idx), .copy_done(copy_done), .state(state),
    .rank_q(failed_rank), .start_q(copy_start)
  );

  assign copy_busy    = (state == ST_COPY);
  assign spare_active = (state == ST_FAILED);

  rsc_events u_evt (
    .clk(clk), .rst_n(rst_n), .busy(copy_busy), .active(spare_active),
    .evt_busy_rise(evt_copy_began), .evt_active_rise(evt_failover)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int NUM_RANKS = 12,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 spare_en,
  input logic [NUM_RANKS-1:0] rank_at_limit,
  input logic                 copy_done,
  input logic                 copy_busy,
  input logic                 spare_active,
  input logic [IDX_W-1:0]     failed_rank,
  input logic                 copy_start,
  input logic                 evt_copy_began,
  input logic                 evt_failover
);
  a_r1_single_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_busy && !spare_active && spare_en && $countones(rank_at_limit) == 1) |=> copy_busy);

  a_r2_not_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_busy && !spare_active && $countones(rank_at_limit) != 1) |=> !copy_busy);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_busy && !copy_done) |=> copy_busy);

  a_r3_done_fails_over: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_busy && copy_done) |=> (spare_active && !copy_busy));

  a_r4_start_matches_event: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start == evt_copy_began);

  a_r4_event_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    evt_copy_began |=> !evt_copy_began);

  a_r5_event_in_failover: assert property (@(posedge clk) disable iff (!rst_n)
    evt_failover |-> spare_active);

  a_r6_failover_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_active && spare_en) |=> spare_active);

  a_r6_failover_release: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_active && !spare_en) |=> !spare_active);

  a_r7_rank_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_busy && !evt_copy_began) |-> $stable(failed_rank));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    spare_active |=> !copy_busy);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_busy && spare_active));
endmodule

bind rank_spare_ctrl rsc_checker #(.NUM_RANKS(NUM_RANKS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spare_en(spare_en), .rank_at_limit(rank_at_limit),
  .copy_done(copy_done), .copy_busy(copy_busy), .spare_active(spare_active),
  .failed_rank(failed_rank), .copy_start(copy_start),
  .evt_copy_began(evt_copy_began), .evt_failover(evt_failover)
);

// File: tb/sim_rank_spare_ctrl.sv
module sim_rank_spare_ctrl;
  localparam int NR = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          spare_en = 1'b0;
  logic [NR-1:0] rank_at_limit = '0;
  logic          copy_done = 1'b0;
  logic          copy_busy, spare_active, copy_start, evt_copy_began, evt_failover;
  logic [3:0]    failed_rank;

  int n_chk = 0, n_bad = 0, cyc = 0;
  // bench model: 0 idle, 1 copy, 2 failed over
  int m_st = 0, m_prev = 0, m_rank = 0;

  always #4 clk = ~clk;

  rank_spare_ctrl #(.NUM_RANKS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .spare_en(spare_en), .rank_at_limit(rank_at_limit),
    .copy_done(copy_done), .copy_busy(copy_busy), .spare_active(spare_active),
    .failed_rank(failed_rank), .copy_start(copy_start),
    .evt_copy_began(evt_copy_began), .evt_failover(evt_failover)
  );

  function automatic int ones(logic [NR-1:0] v);
    int c = 0;
    for (int i = 0; i < NR; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int first_idx(logic [NR-1:0] v);
    for (int i = 0; i < NR; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: inputs applied after falling edge, model stepped, outputs compared after rising edge
  task automatic step(logic en, logic [NR-1:0] lim, logic done);
    @(negedge clk);
    spare_en = en; rank_at_limit = lim; copy_done = done;
    m_prev = m_st;
    case (m_st)
      0: if (en && ones(lim) == 1) begin m_st = 1; m_rank = first_idx(lim); end
      1: if (done) m_st = 2;
      default: if (!en) m_st = 0;
    endcase
    @(posedge clk); #1;
    check(m_prev == 0 ? (ones(lim) == 1 ? "R1" : "R2") : (m_prev == 2 ? "R8" : "R3"),
          "copy_busy", int'(copy_busy), int'(m_st == 1));
    check(m_prev == 2 ? "R6" : "R3", "spare_active", int'(spare_active), int'(m_st == 2));
    check("R4", "copy_start", int'(copy_start), int'(m_st == 1 && m_prev != 1));
    check("R4", "evt_copy_began", int'(evt_copy_began), int'(m_st == 1 && m_prev != 1));
    check("R5", "evt_failover", int'(evt_failover), int'(m_st == 2 && m_prev != 2));
    check("R7", "failed_rank", int'(failed_rank), m_rank);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [NR-1:0] lim;
    logic en;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", "copy_busy", int'(copy_busy), 0);
    check("R10", "spare_active", int'(spare_active), 0);
    check("R10", "copy_start", int'(copy_start), 0);
    check("R10", "evt_failover", int'(evt_failover), 0);
    check("R10", "failed_rank", int'(failed_rank), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: two at limit, no start; R9: done in idle ignored
    step(1'b1, 12'h011, 1'b0);
    step(1'b1, 12'h000, 1'b1);
    step(1'b1, 12'hFFF, 1'b1);
    // R1/R7: top rank, then hold with done low (R3)
    step(1'b1, 12'h800, 1'b0);
    step(1'b0, 12'h003, 1'b0);
    step(1'b1, 12'h000, 1'b0);
    // done together with enable dropping: failover then release (R3, R5, R6)
    step(1'b0, 12'h001, 1'b1);
    step(1'b0, 12'h001, 1'b0);
    // R8: rearm needed; go to failover and try another rank
    step(1'b1, 12'h001, 1'b0);
    step(1'b1, 12'h000, 1'b1);
    step(1'b1, 12'h040, 1'b0);
    step(1'b1, 12'h040, 1'b1);
    step(1'b0, 12'h040, 1'b0);
    step(1'b1, 12'h040, 1'b0);

    // constrained random phase
    en = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      int sel;
      if ($urandom_range(0, 29) == 0) en = ~en;
      sel = int'($urandom_range(0, 7));
      if (sel < 4) lim = '0;
      else if (sel < 6) lim = NR'(1) << $urandom_range(0, NR - 1);
      else if (sel == 6) lim = (NR'(1) << $urandom_range(0, NR - 1)) | (NR'(1) << $urandom_range(0, NR - 1));
      else lim = NR'($urandom);
      step(en, lim, $urandom_range(0, 5) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule